// File: doc/BRIEF.md
# DSP Program Flow Controller

This block steps a small signal processor through its program. It holds the program counter, a circular return-address stack, four loop counters and the sequencing state machine. It drives the address of a program ROM with one cycle of read latency and takes back the instruction word. From that word it produces decode, execute and streaming strobes for the datapath. The block also passes on the current instruction and its optional second word.

An ordinary instruction runs as fetch, decode, execute in three cycles. A word with its long flag set pulls one more word from the ROM. That word carries a constant, a counter preload value or a branch target, so the instruction takes four cycles. The filter instruction switches to a streaming sequence. It raises an element strobe once per cycle for the number of elements it names, then closes with one execute cycle, so N elements take N+3 cycles. Flow-control instructions can update a loop counter, test masked counter flags and an external overflow flag, and then jump, call or return.

Top module: `pfc_flow_ctrl`

## Requirements
- R1: While rst_n is low, and after any reset, rom_addr_o is 0, all three strobes are low and cnt_flag_o is 0.
- R2: A word whose bit 17 is 0 and whose class is not filter takes 3 cycles from its decode strobe to the next decode strobe. Execution continues at the next address, and at most one strobe is high in any cycle.
- R3: Bit 17 set marks a double-length instruction. Its second word is read from the following address and held on imm_o. The instruction takes 4 cycles, and the next sequential address skips the second word.
- R4: Class bits 16:14 = 011 select filter, with the element count N in bits 9:0. elem_stb_o is high for N consecutive cycles and exec_stb_o follows directly. The instruction takes N+3 cycles, or N+4 with bit 17 set. N = 0 takes 3 cycles.
- R5: Class bits 16:14 = 101 select flow control. The fields are: bit 13 jump, bit 12 conditional, bit 4 invert, bit 5 overflow mask, bits 3:0 counter-flag mask. The condition is (ovf_i AND bit 5) OR any flag enabled by bits 3:0. An unconditional instruction is always taken. A conditional one is taken when the condition differs from the invert bit. A taken jump goes to the low address bits of the second word.
- R6: Bit 10 on a taken jump pushes the address that follows the flow instruction. Bit 11 on a taken flow instruction pops the stack into the program counter and overrides bit 13. A return with an empty stack is ignored, and execution continues sequentially.
- R7: The return stack holds 4 entries. A push onto a full stack overwrites the oldest entry, so later returns yield the newest four addresses in reverse order.
- R8: Bits 9:8 give the counter operation (01 decrement, 10 load from the second word) and bits 7:6 select the counter. A decrement from 1 or 0 leaves 0 and sets that counter's flag. A load clears the flag. The same instruction's condition sees the updated flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rom_data_i | input | 18 | Program ROM read data, one cycle after the address |
| ovf_i | input | 1 | Overflow status flag from the datapath |
| rom_addr_o | output | AW (8) | Program ROM address, equal to the program counter |
| decode_stb_o | output | 1 | High in the decode cycle of each instruction |
| exec_stb_o | output | 1 | High in the execute cycle of each instruction |
| elem_stb_o | output | 1 | High in each streaming cycle of a filter instruction |
| instr_o | output | 18 | Current instruction word |
| imm_o | output | 18 | Second word of the current instruction, 0 if none |
| cnt_flag_o | output | 4 | Loop-counter terminal flags, one per counter |

## Verification
The assertions check the ordering of the strobes on every cycle: strobes are exclusive, decode lasts one cycle, execute is followed by a fetch cycle, and streaming ends only in execute. They also check that the stack depth stays within bounds and that counter flags change only after an execute cycle, one flag at a time. Some behaviour only the bench scenarios can show. That includes the cycle counts of each instruction kind and the path taken by counted loops. It also covers the stack's overwrite of its oldest entry after five nested calls, ignored empty returns, and branches on the overflow flag and on masked counter flags.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
    localparam int IW      = 18;
    localparam int NCNT    = 4;
    localparam int FLEN_W  = 10;

    localparam logic [2:0] OPC_FLOW = 3'b101;
    localparam logic [2:0] OPC_FILT = 3'b011;

    localparam logic [1:0] CTR_DEC  = 2'b01;
    localparam logic [1:0] CTR_LOAD = 2'b10;

    typedef enum logic [2:0] {
        S_FETCH  = 3'd0,
        S_DECODE = 3'd1,
        S_WORD2  = 3'd2,
        S_EXEC   = 3'd3,
        S_STREAM = 3'd4
    } seq_state_e;

    // field order matches bits 13..0 of a flow-control word
    typedef struct packed {
        logic            jmp;
        logic            cnd;
        logic            ret;
        logic            call;
        logic [1:0]      cop;
        logic [1:0]      csel;
        logic            omask;
        logic            inv;
        logic [NCNT-1:0] fmask;
    } flow_f_s;

    function automatic flow_f_s split_flow(input logic [IW-1:0] w);
        return flow_f_s'(w[13:0]);
    endfunction

    function automatic logic is_filt(input logic [IW-1:0] w);
        return w[16:14] == OPC_FILT;
    endfunction

    function automatic logic is_flow(input logic [IW-1:0] w);
        return w[16:14] == OPC_FLOW;
    endfunction
endpackage

// File: rtl/pfc_ret_stack.sv
module pfc_ret_stack #(
    parameter int AW    = 8,
    parameter int DEPTH = 4,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int DW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [AW-1:0] push_addr_i,
    output logic [AW-1:0] top_addr_o,
    output logic          empty_o,
    output logic [DW-1:0] depth_o
);
    typedef struct packed {
        logic [DEPTH-1:0][AW-1:0] mem;
        logic [PW-1:0]            wptr;
        logic [DW-1:0]            depth;
    } stk_s;

    stk_s q, d;
    logic [PW-1:0] top_idx;

    always_comb begin
        top_idx = (q.wptr == '0) ? PW'(DEPTH - 1) : q.wptr - PW'(1);
        d = q;
        if (push_i) begin
            d.mem[q.wptr] = push_addr_i;
            d.wptr        = (q.wptr == PW'(DEPTH - 1)) ? '0 : q.wptr + PW'(1);
            if (q.depth != DW'(DEPTH)) begin
                d.depth = q.depth + DW'(1);
            end
        end else if (pop_i && (q.depth != '0)) begin
            d.wptr  = top_idx;
            d.depth = q.depth - DW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign top_addr_o = q.mem[top_idx];
    assign empty_o    = (q.depth == '0);
    assign depth_o    = q.depth;
endmodule

// File: rtl/pfc_loop_ctrs.sv
module pfc_loop_ctrs #(
    parameter int CW  = 16,
    parameter int NC  = 4,
    localparam int SW = (NC > 1) ? $clog2(NC) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic [1:0]    op_i,
    input  logic [SW-1:0] sel_i,
    input  logic [CW-1:0] load_i,
    output logic [NC-1:0] flags_nxt_o,
    output logic [NC-1:0] flags_o
);
    import pfc_pkg::*;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          flg;
    } ctr_s;

    for (genvar g = 0; g < NC; g++) begin : g_ctr
        ctr_s r_q, r_d;

        always_comb begin
            r_d = r_q;
            if (en_i && (sel_i == SW'(g))) begin
                case (op_i)
                    CTR_DEC: begin
                        r_d.cnt = (r_q.cnt > CW'(1)) ? r_q.cnt - CW'(1) : '0;
                        r_d.flg = (r_q.cnt <= CW'(1));
                    end
                    CTR_LOAD: begin
                        r_d.cnt = load_i;
                        r_d.flg = 1'b0;
                    end
                    default: ;
                endcase
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                r_q <= '0;
            end else begin
                r_q <= r_d;
            end
        end

        assign flags_nxt_o[g] = r_d.flg;
        assign flags_o[g]     = r_q.flg;
    end
endmodule

// File: rtl/pfc_branch_eval.sv
module pfc_branch_eval
    import pfc_pkg::*;
(
    input  flow_f_s         fld_i,
    input  logic [NCNT-1:0] flags_i,
    input  logic            ovf_i,
    output logic            take_o
);
    logic hit;

    always_comb begin
        hit    = (|(flags_i & fld_i.fmask)) | (ovf_i & fld_i.omask);
        take_o = !fld_i.cnd | (hit ^ fld_i.inv);
    end
endmodule

// File: rtl/pfc_flow_ctrl.sv
module pfc_flow_ctrl #(
    parameter int AW     = 8,
    parameter int CW     = 16,
    parameter int SDEPTH = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [17:0]           rom_data_i,
    input  logic                  ovf_i,
    output logic [AW-1:0]         rom_addr_o,
    output logic                  decode_stb_o,
    output logic                  exec_stb_o,
    output logic                  elem_stb_o,
    output logic [17:0]           instr_o,
    output logic [17:0]           imm_o,
    output logic [3:0]            cnt_flag_o
);
    import pfc_pkg::*;

    localparam int DW = $clog2(SDEPTH + 1);

    typedef struct packed {
        seq_state_e        st;
        logic [AW-1:0]     pc;
        logic [IW-1:0]     ir;
        logic [IW-1:0]     imm;
        logic [FLEN_W-1:0] ecnt;
    } seq_s;

    seq_s q, d;

    flow_f_s         fld;
    logic            flow_exec;
    logic            take;
    logic            stk_push;
    logic            stk_pop;
    logic            stk_empty;
    logic [AW-1:0]   stk_top;
    logic [DW-1:0]   stk_depth;
    logic [NCNT-1:0] flags_nxt;
    logic [NCNT-1:0] flags_q;

    assign fld       = split_flow(q.ir);
    assign flow_exec = (q.st == S_EXEC) && is_flow(q.ir);

    pfc_loop_ctrs #(.CW(CW), .NC(NCNT)) u_ctrs (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (flow_exec),
        .op_i        (fld.cop),
        .sel_i       (fld.csel),
        .load_i      (q.imm[CW-1:0]),
        .flags_nxt_o (flags_nxt),
        .flags_o     (flags_q)
    );

    pfc_branch_eval u_cond (
        .fld_i   (fld),
        .flags_i (flags_nxt),
        .ovf_i   (ovf_i),
        .take_o  (take)
    );

    pfc_ret_stack #(.AW(AW), .DEPTH(SDEPTH)) u_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (stk_push),
        .pop_i       (stk_pop),
        .push_addr_i (q.pc),
        .top_addr_o  (stk_top),
        .empty_o     (stk_empty),
        .depth_o     (stk_depth)
    );

    always_comb begin
        d        = q;
        stk_push = 1'b0;
        stk_pop  = 1'b0;
        case (q.st)
            S_FETCH: begin
                d.pc = q.pc + AW'(1);
                d.st = S_DECODE;
            end
            S_DECODE: begin
                d.ir   = rom_data_i;
                d.imm  = '0;
                d.ecnt = rom_data_i[FLEN_W-1:0];
                if (rom_data_i[IW-1]) begin
                    d.pc = q.pc + AW'(1);
                    d.st = S_WORD2;
                end else if (is_filt(rom_data_i)) begin
                    d.st = (rom_data_i[FLEN_W-1:0] == '0) ? S_EXEC : S_STREAM;
                end else begin
                    d.st = S_EXEC;
                end
            end
            S_WORD2: begin
                d.imm = rom_data_i;
                if (is_filt(q.ir)) begin
                    d.st = (q.ecnt == '0) ? S_EXEC : S_STREAM;
                end else begin
                    d.st = S_EXEC;
                end
            end
            S_STREAM: begin
                d.ecnt = q.ecnt - FLEN_W'(1);
                if (q.ecnt == FLEN_W'(1)) begin
                    d.st = S_EXEC;
                end
            end
            S_EXEC: begin
                d.st = S_FETCH;
                if (flow_exec && take) begin
                    if (fld.ret) begin
                        if (!stk_empty) begin
                            d.pc    = stk_top;
                            stk_pop = 1'b1;
                        end
                    end else if (fld.jmp) begin
                        d.pc     = q.imm[AW-1:0];
                        stk_push = fld.call;
                    end
                end
            end
            default: d.st = S_FETCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rom_addr_o   = q.pc;
    assign decode_stb_o = (q.st == S_DECODE);
    assign exec_stb_o   = (q.st == S_EXEC);
    assign elem_stb_o   = (q.st == S_STREAM);
    assign instr_o      = q.ir;
    assign imm_o        = q.imm;
    assign cnt_flag_o   = flags_q;
endmodule

// File: rtl/pfc_flow_ctrl_chk.sv
module pfc_flow_ctrl_chk #(
    parameter int SDEPTH = 4,
    parameter int DW     = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          decode_stb,
    input logic          exec_stb,
    input logic          elem_stb,
    input logic [3:0]    flags,
    input logic [DW-1:0] stk_depth
);
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({decode_stb, exec_stb, elem_stb})); // R2

    AST_DECODE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        decode_stb |=> !decode_stb); // R2

    AST_EXEC_THEN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        exec_stb |=> !(decode_stb || exec_stb || elem_stb)); // R2

    AST_STREAM_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        elem_stb |=> (elem_stb || exec_stb)); // R4

    AST_STACK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        stk_depth <= DW'(SDEPTH)); // R7

    AST_FLAG_AFTER_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        (flags != $past(flags)) |-> $past(exec_stb)); // R8

    AST_FLAG_ONE_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(flags ^ $past(flags)) <= 1); // R8
endmodule

bind pfc_flow_ctrl pfc_flow_ctrl_chk #(.SDEPTH(SDEPTH), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .decode_stb (decode_stb_o),
    .exec_stb   (exec_stb_o),
    .elem_stb   (elem_stb_o),
    .flags      (cnt_flag_o),
    .stk_depth  (stk_depth)
);

// File: tb/pfc_flow_ctrl_test.sv
module pfc_flow_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 8;
    localparam int WATCHDOG   = 20000;

    // {instruction address, cycles since previous decode (0 = skip)}
    localparam logic [15:0] TRACE_A [18] = '{
        {8'd0, 8'd0},  {8'd2, 8'd4},  {8'd3, 8'd3},  {8'd2, 8'd4},
        {8'd3, 8'd3},  {8'd2, 8'd4},  {8'd3, 8'd3},  {8'd5, 8'd4},
        {8'd6, 8'd7},  {8'd20, 8'd4}, {8'd21, 8'd3}, {8'd8, 8'd3},
        {8'd9, 8'd3},  {8'd10, 8'd3}, {8'd12, 8'd4}, {8'd40, 8'd4},
        {8'd41, 8'd3}, {8'd41, 8'd4}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [17:0]   rom_q;
    logic          ovf = 1'b0;
    logic [AW-1:0] rom_addr;
    logic          decode_stb, exec_stb, elem_stb;
    logic [17:0]   instr, imm;
    logic [3:0]    cnt_flag;

    logic [17:0]   rom [64];
    int            cyc = 0;
    int            elem_total = 0;
    int            last_dec = 0;
    int            checks = 0;
    int            errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) rom_q <= rom[rom_addr[5:0]];
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if (rst_n && elem_stb) elem_total <= elem_total + 1;

    pfc_flow_ctrl #(.AW(AW)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .rom_data_i   (rom_q),
        .ovf_i        (ovf),
        .rom_addr_o   (rom_addr),
        .decode_stb_o (decode_stb),
        .exec_stb_o   (exec_stb),
        .elem_stb_o   (elem_stb),
        .instr_o      (instr),
        .imm_o        (imm),
        .cnt_flag_o   (cnt_flag)
    );

    function automatic logic [17:0] w_flow(bit il, bit j, bit c, bit r, bit p, bit om,
                                           bit inv, logic [1:0] cop, logic [1:0] sel,
                                           logic [3:0] fm);
        return {il, 3'b101, j, c, r, p, cop, sel, om, inv, fm};
    endfunction

    function automatic logic [17:0] w_filt(bit il, logic [9:0] n);
        return {il, 3'b011, 4'b0000, n};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_rom();
        for (int i = 0; i < 64; i++) rom[i] = 18'h0;
    endtask

    task automatic expect_next(input int a, input int len, input string req);
        int a_seen;
        int gap;
        do @(negedge clk); while (decode_stb !== 1'b1);
        a_seen   = int'(rom_addr) - 1;
        gap      = cyc - last_dec;
        last_dec = cyc;
        chk(a_seen == a, {req, " address"}, a_seen, a);
        if (len > 0) chk(gap == len, {req, " cycles"}, gap, len);
    endtask

    task automatic hold_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(rom_addr == '0, "R1 rom_addr", int'(rom_addr), 0);
        chk({decode_stb, exec_stb, elem_stb} == 3'b000, "R1 strobes",
            int'({decode_stb, exec_stb, elem_stb}), 0);
        chk(cnt_flag == 4'b0000, "R1 flags", int'(cnt_flag), 0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int elem0;
        clear_rom();
        // Program A: counted loop, filter, call/return, empty return, masks
        rom[0]  = w_flow(1, 0, 0, 0, 0, 0, 0, 2'b10, 2'd0, 4'b0000);
        rom[1]  = 18'd3;
        rom[2]  = 18'h0;
        rom[3]  = w_flow(1, 1, 1, 0, 0, 0, 1, 2'b01, 2'd0, 4'b0001);
        rom[4]  = 18'd2;
        rom[5]  = w_filt(0, 10'd4);
        rom[6]  = w_flow(1, 1, 0, 0, 1, 0, 0, 2'b00, 2'd0, 4'b0000);
        rom[7]  = 18'd20;
        rom[8]  = w_flow(0, 0, 0, 1, 0, 0, 0, 2'b00, 2'd0, 4'b0000);
        rom[9]  = w_filt(0, 10'd0);
        rom[10] = w_flow(1, 1, 1, 0, 0, 1, 0, 2'b00, 2'd0, 4'b0000);
        rom[11] = 18'd30;
        rom[12] = w_flow(1, 1, 0, 0, 0, 0, 0, 2'b00, 2'd0, 4'b0000);
        rom[13] = 18'd40;
        rom[20] = 18'h0;
        rom[21] = w_flow(0, 0, 0, 1, 0, 0, 0, 2'b00, 2'd0, 4'b0000);
        rom[40] = 18'h0;
        rom[41] = w_flow(1, 1, 0, 0, 0, 0, 0, 2'b00, 2'd0, 4'b0000);
        rom[42] = 18'd41;

        hold_reset();
        elem0 = elem_total;
        rst_n = 1'b1;
        // trace covers R2 R3 R4 R5 R6 R8
        for (int k = 0; k < 18; k++) begin
            expect_next(int'(TRACE_A[k][15:8]), int'(TRACE_A[k][7:0]), "R2 R3 R4 R5 R6 trace");
        end
        chk(cnt_flag == 4'b0001, "R8 loop flag", int'(cnt_flag), 1);
        chk(elem_total - elem0 == 4, "R4 element strobes", elem_total - elem0, 4);
        chk(imm == 18'd41, "R3 second word on imm_o", int'(imm), 41);

        // R1: reset in mid-run clears flags and returns to address 0
        hold_reset();

        // Program B: five nested calls on a 4-deep stack
        clear_rom();
        rom[0]  = w_flow(1, 1, 0, 0, 1, 0, 0, 2'b00, 2'd0, 4'b0000); rom[1]  = 18'd20;
        rom[20] = w_flow(1, 1, 0, 0, 1, 0, 0, 2'b00, 2'd0, 4'b0000); rom[21] = 18'd30;
        rom[30] = w_flow(1, 1, 0, 0, 1, 0, 0, 2'b00, 2'd0, 4'b0000); rom[31] = 18'd40;
        rom[40] = w_flow(1, 1, 0, 0, 1, 0, 0, 2'b00, 2'd0, 4'b0000); rom[41] = 18'd50;
        rom[50] = w_flow(1, 1, 0, 0, 1, 0, 0, 2'b00, 2'd0, 4'b0000); rom[51] = 18'd60;
        rom[60] = w_flow(0, 0, 0, 1, 0, 0, 0, 2'b00, 2'd0, 4'b0000);
        rom[52] = w_flow(0, 0, 0, 1, 0, 0, 0, 2'b00, 2'd0, 4'b0000);
        rom[42] = w_flow(0, 0, 0, 1, 0, 0, 0, 2'b00, 2'd0, 4'b0000);
        rom[32] = w_flow(0, 0, 0, 1, 0, 0, 0, 2'b00, 2'd0, 4'b0000);
        rom[22] = w_flow(0, 0, 0, 1, 0, 0, 0, 2'b00, 2'd0, 4'b0000);
        rom[23] = w_flow(1, 1, 0, 0, 0, 0, 0, 2'b00, 2'd0, 4'b0000); rom[24] = 18'd23;
        rst_n = 1'b1;
        expect_next(0, 0, "R6 call");
        expect_next(20, 4, "R6 call");
        expect_next(30, 4, "R6 call");
        expect_next(40, 4, "R6 call");
        expect_next(50, 4, "R6 call");
        expect_next(60, 4, "R7 fifth call");
        expect_next(52, 3, "R7 newest return");
        expect_next(42, 3, "R7 return");
        expect_next(32, 3, "R7 return");
        expect_next(22, 3, "R7 oldest kept return");
        expect_next(23, 3, "R7 overwritten entry not returned");
        expect_next(23, 4, "R6 halt");

        // Program C: overflow branch, decrement at zero, mask selection
        hold_reset();
        clear_rom();
        ovf = 1'b1;
        rom[0]  = w_flow(1, 1, 1, 0, 0, 1, 0, 2'b00, 2'd0, 4'b0000); rom[1]  = 18'd10;
        rom[10] = w_flow(0, 0, 0, 0, 0, 0, 0, 2'b01, 2'd1, 4'b0000);
        rom[11] = w_flow(1, 1, 1, 0, 0, 0, 0, 2'b00, 2'd0, 4'b0100); rom[12] = 18'd30;
        rom[13] = w_flow(1, 1, 1, 0, 0, 0, 0, 2'b00, 2'd0, 4'b0010); rom[14] = 18'd20;
        rom[20] = w_flow(1, 1, 0, 0, 0, 0, 0, 2'b00, 2'd0, 4'b0000); rom[21] = 18'd20;
        rst_n = 1'b1;
        expect_next(0, 0, "R5 overflow");
        expect_next(10, 4, "R5 overflow branch taken");
        expect_next(11, 3, "R8 decrement");
        expect_next(13, 4, "R5 unmasked flag ignored");
        expect_next(20, 4, "R5 masked flag taken");
        chk(cnt_flag == 4'b0010, "R8 decrement at zero sets flag", int'(cnt_flag), 2);
        expect_next(20, 4, "R3 halt");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule